// File: doc/BRIEF.md
# Character LCD Power-Up Command Sequencer

This block brings a two-line character LCD controller out of reset without software help. After a synchronous reset it walks through a fixed list of eight instructions. Each instruction goes out as one short write transaction over a byte-level handshake into a simple serial-bus master. The master turns the bytes into bus traffic and reports whether each byte was acknowledged.

Each transaction carries three bytes: the write address of the display controller, a control byte that marks the next byte as an instruction, and the instruction itself. The list first selects the extended instruction table, then programs the oscillator, contrast, power and follower settings, then turns the display on and clears it. A strap input chooses between two sets of analog settings for a 3 V or a 5 V supply. Parameterized idle gaps separate the transactions. There is a long settle gap after the follower command, so the booster can stabilize, and another long gap after the clear, because the controller cannot be polled. After that gap `done` rises. A byte that is not acknowledged stops the sequence and raises `err`.

Top module: `lcd_boot_seq`

## Requirements
- R1: While `rst` is high, `wr_req`, `done` and `err` are low. `wr_req` rises on the first clock edge after `rst` falls.
- R2: Each transaction is exactly three bytes. The first is 7Ch (the 7-bit address 0111110 followed by a 0 write bit) with `wr_start` high. The second is 00h. The third is the instruction, with `wr_stop` high.
- R3: While `wr_req` is high and no `wr_ack` has been taken, `wr_data`, `wr_start` and `wr_stop` hold their values.
- R4: The instructions go out in this order: 38h, 39h, 14h, three supply-dependent bytes, 0Ch, 01h.
- R5: With `volt5_sel` low during reset, the supply-dependent bytes are 74h, 54h, 6Fh.
- R6: With `volt5_sel` high during reset, the supply-dependent bytes are 79h, 50h, 6Ch.
- R7: `volt5_sel` is sampled only while `rst` is high. Changing it later has no effect on the bytes sent.
- R8: After the acknowledge of an ordinary instruction's last byte, `wr_req` stays low for exactly `CMD_WAIT` cycles before the next transaction.
- R9: After the follower instruction (the sixth), the idle gap is `SETTLE_WAIT` cycles.
- R10: `done` rises exactly `CLEAR_WAIT` cycles after the acknowledge of the clear instruction. It then stays high and `wr_req` stays low.
- R11: An acknowledge with `wr_nack` high sets `err` on that edge. `err` stays high, no further request is made, and `done` never rises.
- R12: Asserting `rst` in the middle of a sequence clears `done` and `err` and restarts the sequence from the first byte of the 38h transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| volt5_sel | input | 1 | Supply strap: 1 selects the 5 V settings, 0 the 3 V settings |
| wr_ack | input | 1 | One-cycle pulse from the master: current byte handled |
| wr_nack | input | 1 | Qualifies `wr_ack`: the byte was not acknowledged on the bus |
| wr_req | output | 1 | Byte request to the master |
| wr_data | output | 8 | Byte to transmit |
| wr_start | output | 1 | Current byte opens a transaction (start condition first) |
| wr_stop | output | 1 | Current byte closes a transaction (stop condition after) |
| done | output | 1 | Sequence complete |
| err | output | 1 | Sequence aborted on a missing acknowledge |

## Verification
The hardest situations to reach from the ports are the ones that depend on history: a strap change after reset, a reset in the middle of a transaction, and a missing acknowledge on a byte deep inside the list. The bench acts as the downstream master, answering each request after a short latency. This lets it decide, byte by byte, when to toggle the strap, when to reset, and which acknowledge carries `wr_nack`. It also counts idle cycles between transactions to measure each gap exactly, including the long settle gap and the final gap before `done`.

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq #(
  parameter int CMD_WAIT    = 2500,
  parameter int SETTLE_WAIT = 10_000_000,
  parameter int CLEAR_WAIT  = 100_000,
  parameter logic [6:0] DEV_ADDR = 7'h3E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       volt5_sel,
  input  logic       wr_ack,
  input  logic       wr_nack,
  output logic       wr_req,
  output logic [7:0] wr_data,
  output logic       wr_start,
  output logic       wr_stop,
  output logic       done,
  output logic       err
);
  localparam int LONG1   = (CMD_WAIT > SETTLE_WAIT) ? CMD_WAIT : SETTLE_WAIT;
  localparam int LONGEST = (LONG1 > CLEAR_WAIT) ? LONG1 : CLEAR_WAIT;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [2:0] LAST_IDX   = 3'd7;
  localparam logic [2:0] FOLLOW_IDX = 3'd5;

  typedef enum logic [2:0] {ST_BOOT, ST_SEND, ST_GAP, ST_DONE, ST_ERR} st_t;

  st_t st;
  logic [2:0] idx;
  logic [1:0] ph;
  logic [CW-1:0] cnt;
  logic v5_q;
  logic [7:0] cmd;
  logic [CW-1:0] gap_len;

  always_comb begin
    case (idx)
      3'd0: cmd = 8'h38;
      3'd1: cmd = 8'h39;
      3'd2: cmd = 8'h14;
      3'd3: cmd = v5_q ? 8'h79 : 8'h74;
      3'd4: cmd = v5_q ? 8'h50 : 8'h54;
      3'd5: cmd = v5_q ? 8'h6C : 8'h6F;
      3'd6: cmd = 8'h0C;
      default: cmd = 8'h01;
    endcase
  end

  always_comb begin
    if (idx == FOLLOW_IDX)    gap_len = CW'(SETTLE_WAIT - 1);
    else if (idx == LAST_IDX) gap_len = CW'(CLEAR_WAIT - 1);
    else                      gap_len = CW'(CMD_WAIT - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_BOOT;
      idx  <= '0;
      ph   <= '0;
      cnt  <= '0;
      v5_q <= volt5_sel;
    end else begin
      case (st)
        ST_BOOT: st <= ST_SEND;
        ST_SEND: if (wr_ack) begin
          if (wr_nack) st <= ST_ERR;
          else if (ph == 2'd2) begin
            ph  <= '0;
            cnt <= gap_len;
            st  <= ST_GAP;
          end else ph <= ph + 2'd1;
        end
        ST_GAP: if (cnt == '0) begin
          if (idx == LAST_IDX) st <= ST_DONE;
          else begin
            idx <= idx + 3'd1;
            st  <= ST_SEND;
          end
        end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign wr_req   = (st == ST_SEND);
  assign wr_start = (ph == 2'd0);
  assign wr_stop  = (ph == 2'd2);
  assign wr_data  = (ph == 2'd0) ? {DEV_ADDR, 1'b0} : (ph == 2'd1) ? 8'h00 : cmd;
  assign done     = (st == ST_DONE);
  assign err      = (st == ST_ERR);

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |=> !wr_req && !done && !err);

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_data) && $stable(wr_start) && $stable(wr_stop));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !wr_req);

  assert_nack_stops_R11: assert property (@(posedge clk) disable iff (rst)
    wr_req && wr_ack && wr_nack |=> err && !wr_req);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err |=> err && !done);

  assert_exclusive_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_req, done, err}));
endmodule

// File: tb/sim_lcd_boot_seq.sv
module sim_lcd_boot_seq;
  localparam int CW_T = 5, SW_T = 40, LW_T = 25;

  logic clk = 0, rst = 1, v5 = 0, ack = 0, nack = 0;
  logic req, first, last, done, err;
  logic [7:0] data;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lcd_boot_seq #(.CMD_WAIT(CW_T), .SETTLE_WAIT(SW_T), .CLEAR_WAIT(LW_T)) u0 (
    .clk(clk), .rst(rst), .volt5_sel(v5), .wr_ack(ack), .wr_nack(nack),
    .wr_req(req), .wr_data(data), .wr_start(first), .wr_stop(last),
    .done(done), .err(err));

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input int c, input bit v);
    case (c)
      0: return 8'h38; 1: return 8'h39; 2: return 8'h14;
      3: return v ? 8'h79 : 8'h74;
      4: return v ? 8'h50 : 8'h54;
      5: return v ? 8'h6C : 8'h6F;
      6: return 8'h0C;
      default: return 8'h01;
    endcase
  endfunction

  task automatic serve(output logic [7:0] d, output logic s, output logic p,
                       output int gap, input bit give_nack);
    gap = 0;
    while (!req && gap < 1000) begin gap++; @(negedge clk); end
    d = data; s = first; p = last;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(req && data == d && first == s && last == p, "R3 hold", data, d);
    end
    ack = 1; nack = give_nack;
    @(negedge clk);
    ack = 0; nack = 0;
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst = 1; v5 = v;
    repeat (3) @(negedge clk);
    check(!req && !done && !err, "R1 reset outputs", {req, done, err}, 0);
    rst = 0;
    @(negedge clk);
    check(req === 1'b1, "R1 first request", req, 1);
  endtask

  task automatic check_cmd(input int c, input bit v, input bit flip, input bit final_part);
    logic [7:0] d; logic s, p; int g;
    for (int b = 0; b < 3; b++) begin
      serve(d, s, p, g, 1'b0);
      if (b == 0) begin
        check(d == 8'h7C && s && !p, "R2 address byte", {s, p, d}, 10'h27C);
        if (c > 0) begin
          if (c - 1 == 5) check(g == SW_T, "R9 settle gap", g, SW_T);
          else            check(g == CW_T, "R8 command gap", g, CW_T);
        end
      end else if (b == 1) begin
        check(d == 8'h00 && !s && !p, "R2 control byte", d, 0);
        check(g == 0, "R2 back-to-back bytes", g, 0);
        if (flip) v5 = ~v5;
      end else begin
        if (c >= 3 && c <= 5)
          check(d == exp_cmd(c, v), v ? "R6 5V byte (R7 strap)" : "R5 3V byte (R7 strap)", d, exp_cmd(c, v));
        else
          check(d == exp_cmd(c, v), "R4 instruction order", d, exp_cmd(c, v));
        check(p && !s, "R2 stop flag", {s, p}, 1);
      end
    end
  endtask

  task automatic t_full(input bit v, input bit flip);
    int n = 0;
    do_reset(v);
    for (int c = 0; c < 8; c++) check_cmd(c, v, flip && c == 2, 1'b0);
    while (!done && n < 1000) begin
      if (req) n = 2000;
      n++; @(negedge clk);
    end
    check(n == LW_T, "R10 clear gap before done", n, LW_T);
    repeat (10) @(negedge clk);
    check(done && !req && !err, "R10 done sticky", {done, req, err}, 4);
  endtask

  task automatic t_nack();
    logic [7:0] d; logic s, p; int g;
    do_reset(1'b0);
    check_cmd(0, 1'b0, 1'b0, 1'b0);
    serve(d, s, p, g, 1'b0);
    serve(d, s, p, g, 1'b1);
    check(err && !req, "R11 error on nack", {err, req}, 2);
    repeat (60) @(negedge clk);
    check(err && !req && !done, "R11 error sticky", {err, req, done}, 4);
  endtask

  task automatic t_midreset();
    logic [7:0] d; logic s, p; int g;
    do_reset(1'b1);
    check_cmd(0, 1'b1, 1'b0, 1'b0);
    serve(d, s, p, g, 1'b0);
    do_reset(1'b1);
    serve(d, s, p, g, 1'b0);
    check(d == 8'h7C && s, "R12 restart at address byte", d, 8'h7C);
    serve(d, s, p, g, 1'b0);
    serve(d, s, p, g, 1'b0);
    check(d == 8'h38, "R12 restart at first instruction", d, 8'h38);
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_full(1'b0, 1'b0);
    t_full(1'b1, 1'b0);
    t_full(1'b0, 1'b1);
    t_nack();
    t_midreset();
    t_full(1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule